// File: doc/BRIEF.md
# PLL Fastlock Timeout Controller

This block governs the fastlock behaviour of a frequency synthesizer loop. Software writes a 24-bit register word. The low three bits carry an address, and bits 14 to 3 carry a 12-bit timeout word. The synthesizer supplies a one-cycle pulse for each phase-detector event. From these inputs the block drives a tri-stateable pin, made of a drive value and an output enable. It also produces a charge-pump gain select, which either forces high gain or passes the user gain bit through.

The timeout word has two roles. Codes 0 to 3 pick a static pin and gain mode. Codes 4 and above start an automatic fastlock that lasts exactly that many phase-detector events. A write is not applied at once. It is held as pending and takes effect on the next event, which also restarts any countdown from the new value. All outputs are registered, and each one changes in the same cycle as the state it reflects.

Top module: `fastlock_timeout_ctrl`

## Requirements
- R1: After synchronous reset the active code is 0: pin_oe=0, pin_out=0, busy=0, pending=0, and gain_hi follows user_gain.
- R2: With active code 0, pin_oe=0 and gain_hi equals the user_gain value sampled at the same clock edge.
- R3: With active code 1, pin_oe=1, pin_out=0 and gain_hi=1 (manual fastlock).
- R4: With active code 2, pin_oe=1, pin_out=0 and gain_hi follows user_gain.
- R5: With active code 3, pin_oe=1, pin_out=1 and gain_hi follows user_gain.
- R6: With an active code from 4 to 4095 and the countdown non-zero, pin_oe=1, pin_out=0 and gain_hi=1. Once the countdown reaches zero, pin_oe=0 and gain_hi follows user_gain.
- R7: An active code of N (N from 4 to 4095) loads the countdown with N on the latching event. Each later event decrements it by one. busy is high while the count is non-zero, so busy drops on exactly the Nth event after the latching one.
- R8: An accepted write sets pending=1 and leaves the pin and gain outputs unchanged. The next event copies the pending code into the active code and clears pending.
- R9: A second write before the latching event replaces the pending code. When a write latches during a running countdown, the count restarts from the new code.
- R10: A write is accepted only when bits 2:0 equal 3'b010 and bits 23:15 are all zero. Any other word leaves pending and all outputs unchanged.
- R11: The timeout code is taken from bits 14:3 of the write word, with bit 3 as its least significant bit.
- R12: A write in the same cycle as an event becomes pending. That event latches the code that was pending before it, and the new code is applied only on the following event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_word | input | 24 | Register word: address [2:0], timeout code [14:3], zero [23:15] |
| pd_evt | input | 1 | One-cycle pulse per phase-detector event |
| user_gain | input | 1 | User charge-pump gain bit |
| pin_out | output | 1 | Drive value of the fastlock pin |
| pin_oe | output | 1 | Output enable of the fastlock pin (0 = high impedance) |
| gain_hi | output | 1 | Charge-pump high-gain select |
| busy | output | 1 | Automatic countdown running |
| pending | output | 1 | Written code waiting for the next event |

## Verification
The assertions assume that pd_evt is a single-cycle pulse sampled on the clock and that wr_word is meaningful only while wr_en is high. They also take a write and an event in the same cycle as legal, with the rule of R12. The stimulus always drives inputs on the falling edge and keeps events at least two cycles apart. It places writes before events, in the middle of countdowns, and in the same cycle as an event, so that each ordering the assertions cover actually occurs. The behavioural model in the bench recomputes every output from these same input rules on each clock.

// File: rtl/fl_pkg.sv
package fl_pkg;

  typedef enum logic [1:0] {
    PIN_HIZ  = 2'd0,
    PIN_LOW  = 2'd1,
    PIN_HIGH = 2'd2
  } pin_mode_e;

  typedef struct packed {
    pin_mode_e pin;
    logic      force_hi;
  } drive_t;

endpackage

// File: rtl/fl_wr_capture.sv
module fl_wr_capture #(
  parameter int          WW   = 24,
  parameter int          AW   = 3,
  parameter int          TW   = 12,
  parameter logic [AW-1:0] ADDR = 3'b010
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [WW-1:0] wr_word,
  input  logic          pd_evt,
  output logic          pend_q,
  output logic [TW-1:0] pend_val_q,
  output logic          latch
);
  localparam int LSB = AW;
  localparam int MSB = AW + TW - 1;
  localparam int RSV = WW - AW - TW;

  logic          wr_hit;
  logic [TW-1:0] field;

  generate
    if (RSV > 0) begin : g_rsv
      assign wr_hit = wr_en && (wr_word[AW-1:0] == ADDR) && (wr_word[WW-1:MSB+1] == '0);
    end else begin : g_norsv
      assign wr_hit = wr_en && (wr_word[AW-1:0] == ADDR);
    end
  endgenerate

  assign field = wr_word[MSB:LSB];
  assign latch = pd_evt && pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= 1'b0;
      pend_val_q <= '0;
    end else if (wr_hit) begin
      pend_q     <= 1'b1;
      pend_val_q <= field;
    end else if (pd_evt) begin
      pend_q     <= 1'b0;
    end
  end

  AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (pd_evt && !wr_hit) |=> !pend_q); // R8

  AST_MISS_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!wr_hit && !pd_evt) |=> ($stable(pend_q) && $stable(pend_val_q))); // R10

  AST_HIT_SETS: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> (pend_q && pend_val_q == $past(field))); // R11

endmodule

// File: rtl/fl_active_reg.sv
module fl_active_reg #(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          latch,
  input  logic [TW-1:0] pend_val,
  output logic [TW-1:0] act_q,
  output logic [TW-1:0] act_nxt
);
  assign act_nxt = latch ? pend_val : act_q;

  always_ff @(posedge clk) begin
    if (rst) act_q <= '0;
    else     act_q <= act_nxt;
  end

  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !latch |=> $stable(act_q)); // R8

endmodule

// File: rtl/fl_countdown.sv
module fl_countdown #(
  parameter int TW       = 12,
  parameter int AUTO_MIN = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pd_evt,
  input  logic          latch,
  input  logic [TW-1:0] pend_val,
  output logic [TW-1:0] cnt_nxt
);
  localparam logic [TW-1:0] MIN_V = TW'(AUTO_MIN);

  logic [TW-1:0] cnt_q;
  logic          is_auto;

  assign is_auto = (pend_val >= MIN_V);

  always_comb begin
    cnt_nxt = cnt_q;
    if (latch)                       cnt_nxt = is_auto ? pend_val : '0;
    else if (pd_evt && cnt_q != '0)  cnt_nxt = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end

  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (rst)
    (latch && is_auto) |=> (cnt_q == $past(pend_val))); // R9

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (pd_evt && !latch && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R7

  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !pd_evt |=> $stable(cnt_q)); // R7

endmodule

// File: rtl/fl_pin_drive.sv
module fl_pin_drive
  import fl_pkg::*;
#(
  parameter int TW       = 12,
  parameter int AUTO_MIN = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] act_nxt,
  input  logic [TW-1:0] cnt_nxt,
  input  logic          user_gain,
  output logic          pin_out,
  output logic          pin_oe,
  output logic          gain_hi,
  output logic          busy
);
  localparam logic [TW-1:0] MIN_V = TW'(AUTO_MIN);

  drive_t drv;
  logic   run_nxt;

  assign run_nxt = (cnt_nxt != '0);

  always_comb begin
    drv = '{pin: PIN_HIZ, force_hi: 1'b0};
    if (act_nxt >= MIN_V) begin
      if (run_nxt) drv = '{pin: PIN_LOW, force_hi: 1'b1};
    end else begin
      case (act_nxt[1:0])
        2'd1:    drv = '{pin: PIN_LOW,  force_hi: 1'b1};
        2'd2:    drv = '{pin: PIN_LOW,  force_hi: 1'b0};
        2'd3:    drv = '{pin: PIN_HIGH, force_hi: 1'b0};
        default: drv = '{pin: PIN_HIZ,  force_hi: 1'b0};
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= 1'b0;
      pin_oe  <= 1'b0;
      gain_hi <= user_gain;
      busy    <= 1'b0;
    end else begin
      pin_out <= (drv.pin == PIN_HIGH);
      pin_oe  <= (drv.pin != PIN_HIZ);
      gain_hi <= drv.force_hi | user_gain;
      busy    <= run_nxt;
    end
  end

  AST_HIZ_LOW: assert property (@(posedge clk) disable iff (rst)
    !pin_oe |-> !pin_out); // R2

endmodule

// File: rtl/fastlock_timeout_ctrl.sv
module fastlock_timeout_ctrl #(
  parameter int            WW       = 24,
  parameter int            AW       = 3,
  parameter int            TW       = 12,
  parameter logic [AW-1:0] ADDR     = 3'b010,
  parameter int            AUTO_MIN = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [WW-1:0] wr_word,
  input  logic          pd_evt,
  input  logic          user_gain,
  output logic          pin_out,
  output logic          pin_oe,
  output logic          gain_hi,
  output logic          busy,
  output logic          pending
);
  logic [TW-1:0] pend_val;
  logic          latch;
  logic [TW-1:0] act_q;
  logic [TW-1:0] act_nxt;
  logic [TW-1:0] cnt_nxt;

  fl_wr_capture #(.WW(WW), .AW(AW), .TW(TW), .ADDR(ADDR)) i_cap (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_word(wr_word), .pd_evt(pd_evt),
    .pend_q(pending), .pend_val_q(pend_val), .latch(latch)
  );

  fl_active_reg #(.TW(TW)) i_act (
    .clk(clk), .rst(rst), .latch(latch), .pend_val(pend_val),
    .act_q(act_q), .act_nxt(act_nxt)
  );

  fl_countdown #(.TW(TW), .AUTO_MIN(AUTO_MIN)) i_cnt (
    .clk(clk), .rst(rst), .pd_evt(pd_evt), .latch(latch), .pend_val(pend_val),
    .cnt_nxt(cnt_nxt)
  );

  fl_pin_drive #(.TW(TW), .AUTO_MIN(AUTO_MIN)) i_drv (
    .clk(clk), .rst(rst), .act_nxt(act_nxt), .cnt_nxt(cnt_nxt), .user_gain(user_gain),
    .pin_out(pin_out), .pin_oe(pin_oe), .gain_hi(gain_hi), .busy(busy)
  );

  AST_BUSY_FORCES: assert property (@(posedge clk) disable iff (rst)
    busy |-> (gain_hi && pin_oe && !pin_out)); // R6

  AST_CODE0_HIZ: assert property (@(posedge clk) disable iff (rst)
    (act_q == '0) |-> (!pin_oe && !busy)); // R2

  AST_CODE1_MANUAL: assert property (@(posedge clk) disable iff (rst)
    (act_q == TW'(1)) |-> (pin_oe && !pin_out && gain_hi)); // R3

  AST_CODE3_HIGH: assert property (@(posedge clk) disable iff (rst)
    (act_q == TW'(3)) |-> (pin_oe && pin_out)); // R5

  AST_BUSY_ONLY_AUTO: assert property (@(posedge clk) disable iff (rst)
    busy |-> (act_q >= TW'(AUTO_MIN))); // R7

endmodule

// File: tb/test_fastlock_timeout_ctrl.sv
module test_fastlock_timeout_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [23:0] wr_word = '0;
  logic        pd_evt = 1'b0;
  logic        user_gain = 1'b0;
  logic        pin_out, pin_oe, gain_hi, busy, pending;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int m_act = 0, m_cnt = 0, m_pv = 0;
  bit m_pend = 0;
  bit e_out = 0, e_oe = 0, e_gain = 0, e_busy = 0;

  always #2 clk = ~clk;

  fastlock_timeout_ctrl i_fastlock_timeout_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_word(wr_word), .pd_evt(pd_evt),
    .user_gain(user_gain), .pin_out(pin_out), .pin_oe(pin_oe), .gain_hi(gain_hi),
    .busy(busy), .pending(pending)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model, updated on every rising edge
  always @(posedge clk) begin
    bit hit, lat;
    if (rst) begin
      m_act = 0; m_cnt = 0; m_pv = 0; m_pend = 0;
    end else begin
      hit = wr_en && (wr_word[2:0] == 3'b010) && (wr_word[23:15] == 9'd0);
      lat = pd_evt && m_pend;
      if (lat) begin
        m_act = m_pv;
        m_cnt = (m_pv >= 4) ? m_pv : 0;
      end else if (pd_evt && m_cnt > 0) begin
        m_cnt = m_cnt - 1;
      end
      if (hit) begin
        m_pend = 1; m_pv = int'(wr_word[14:3]);
      end else if (pd_evt) begin
        m_pend = 0;
      end
    end
    e_busy = (m_cnt != 0);
    e_out = 0; e_oe = 0; e_gain = user_gain;
    if (m_act >= 4) begin
      if (m_cnt != 0) begin e_oe = 1; e_gain = 1; end
    end else if (m_act == 1) begin e_oe = 1; e_gain = 1; end
    else if (m_act == 2) begin e_oe = 1; end
    else if (m_act == 3) begin e_oe = 1; e_out = 1; end
  end

  // Compare against the model on every falling edge
  always @(negedge clk) begin
    string tag;
    if (!rst && !done) begin
      case (m_act)
        0: tag = "R2"; 1: tag = "R3"; 2: tag = "R4"; 3: tag = "R5";
        default: tag = "R6";
      endcase
      chk(pin_oe == e_oe, {tag, " pin_oe"}, int'(pin_oe), int'(e_oe));
      chk(pin_out == e_out, {tag, " pin_out"}, int'(pin_out), int'(e_out));
      chk(gain_hi == e_gain, {tag, " gain_hi"}, int'(gain_hi), int'(e_gain));
      chk(busy == e_busy, "R7 busy", int'(busy), int'(e_busy));
      chk(pending == m_pend, "R8 pending", int'(pending), int'(m_pend));
    end
  end

  initial begin
    forever begin
      repeat (5) @(negedge clk);
      user_gain = ~user_gain;
    end
  end

  task automatic wr_raw(input logic [23:0] w);
    @(negedge clk); wr_en = 1'b1; wr_word = w;
    @(negedge clk); wr_en = 1'b0; wr_word = '0;
  endtask

  // R11: code placed at bits 14:3, address 3'b010 at bits 2:0
  task automatic wr_code(input int v);
    wr_raw({9'd0, 12'(v), 3'b010});
  endtask

  task automatic evt();
    @(negedge clk); pd_evt = 1'b1;
    @(negedge clk); pd_evt = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_auto(input int n);
    int k;
    wr_code(n);
    evt();
    chk(busy == 1'b1, "R7 busy after latch", int'(busy), 1);
    k = 0;
    do begin evt(); k++; end while (busy && k < 5000);
    chk(k == n, "R7 fastlock event count", k, n);
    chk(pin_oe == 1'b0, "R6 hiz after timeout", int'(pin_oe), 0);
  endtask

  initial begin
    int k;
    repeat (3) @(negedge clk);
    chk(pin_oe == 0 && busy == 0 && pending == 0 && pin_out == 0, "R1 reset state",
        int'({pin_oe, pin_out, busy, pending}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(pin_oe == 0, "R1 idle after reset", int'(pin_oe), 0);

    // Static codes 0..3
    for (int v = 0; v < 4; v++) begin
      wr_code(3 - v);
      chk(pending == 1, "R8 pending after write", int'(pending), 1);
      evt();
      chk(pending == 0, "R8 pending cleared", int'(pending), 0);
      repeat (3) evt();
    end
    wr_code(3); evt();
    chk(pin_out == 1 && pin_oe == 1, "R11 field position code 3",
        int'({pin_oe, pin_out}), 3);
    wr_code(1); @(negedge clk);
    chk(pin_out == 1, "R8 write not applied before event", int'(pin_out), 1);
    evt();
    chk(gain_hi == 1, "R3 manual gain", int'(gain_hi), 1);

    // Automatic countdowns
    run_auto(4);
    run_auto(5);
    run_auto(4095);

    // Overwrite during countdown restarts from new code
    wr_code(10); evt();
    repeat (3) evt();
    wr_code(20); wr_code(6);
    evt();
    k = 0;
    do begin evt(); k++; end while (busy && k < 5000);
    chk(k == 6, "R9 restart from replacing code", k, 6);

    // Rejected writes
    wr_raw({9'd0, 12'd1, 3'b011});
    chk(pending == 0, "R10 wrong address ignored", int'(pending), 0);
    wr_raw({9'd1, 12'd1, 3'b010});
    chk(pending == 0, "R10 reserved bits ignored", int'(pending), 0);
    evt();
    chk(pin_oe == 0, "R10 outputs unchanged", int'(pin_oe), 0);

    // Write coinciding with an event
    wr_code(2);
    @(negedge clk); pd_evt = 1'b1; wr_en = 1'b1; wr_word = {9'd0, 12'd1, 3'b010};
    @(negedge clk); pd_evt = 1'b0; wr_en = 1'b0; wr_word = '0;
    chk(pending == 1, "R12 coincident write pending", int'(pending), 1);
    chk(pin_oe == 1 && pin_out == 0, "R12 older code latched", int'({pin_oe, pin_out}), 2);
    evt();
    chk(gain_hi == 1 && pending == 0, "R12 new code on next event",
        int'({gain_hi, pending}), 2);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(150000 * 4);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule